// File: doc/BRIEF.md
# USB Host Port Power and Overcurrent Conditioner

This block sits between a USB host controller and the board-level power switch of one downstream port. On the pin side it drives the physical enable of the port's power switch and receives the physical overcurrent indication from that switch. On the controller side it takes a normalised power request, where 1 means "power on", and returns a normalised overcurrent flag, where 1 means "fault". It also returns the power state it is currently granting.

Each of the two signals has its own availability bit and its own polarity bit. When a board has no power-switch pin, software clears both the power-control enable and its polarity bit. The power pin then rests at a fixed inactive level. The overcurrent pin is asynchronous to the controller clock. It passes through a two-flop synchroniser, then through the polarity correction, and then through the availability gate. While an overcurrent is flagged, the block withdraws port power by itself one cycle later, without waiting for the controller to drop its request.

Top module: `usb_port_pwr_cond`

## Requirements
- R1: While `rst_n` is low, `pwr_act` is 0 and `oc_flag` is 0 when `cfg_oc_en` is 0. `pwr_pin` is at the inactive level for `cfg_pp_hi`, meaning 1 when `cfg_pp_hi` is 0 and 0 when `cfg_pp_hi` is 1.
- R2: With `cfg_oc_en`=1 and `cfg_oc_hi`=1, a high `oc_pin` is an overcurrent. `oc_flag` follows a change on `oc_pin` after exactly two rising clock edges, and not after one.
- R3: With `cfg_oc_en`=1 and `cfg_oc_hi`=0, a low `oc_pin` is an overcurrent. `oc_flag` is the synchronised pin level inverted.
- R4: With `cfg_oc_en`=0, `oc_flag` is 0 whatever level `oc_pin` has.
- R5: With `cfg_pp_en`=1, after each rising edge `pwr_act` equals the value of `pwr_req AND NOT oc_flag` sampled at that edge.
- R6: With `cfg_pp_en`=1, `pwr_pin` equals `pwr_act` when `cfg_pp_hi`=1 and equals NOT `pwr_act` when `cfg_pp_hi`=0. A change of `cfg_pp_hi` shows on the pin in the same cycle.
- R7: With `cfg_pp_en`=0, `pwr_act` is 0 and `pwr_pin` is driven to NOT `cfg_pp_hi` in the same cycle, whatever `pwr_req` is.
- R8: When `oc_flag` is 1 while `cfg_pp_en`=1, `pwr_act` is 0 after the next rising edge. It stays 0 for as long as the flag stays set, even with `pwr_req` held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pp_en | input | 1 | 1 = port-power control available |
| cfg_pp_hi | input | 1 | 1 = power pin active-high, 0 = active-low |
| cfg_oc_en | input | 1 | 1 = overcurrent sensing available |
| cfg_oc_hi | input | 1 | 1 = overcurrent pin active-high, 0 = active-low |
| pwr_req | input | 1 | Normalised power request from the controller |
| oc_pin | input | 1 | Raw overcurrent level from the board |
| pwr_pin | output | 1 | Physical power-switch enable level |
| pwr_act | output | 1 | Normalised power state being granted |
| oc_flag | output | 1 | Normalised, synchronised overcurrent flag |

## Verification
The latency assertions assume that the configuration bits stay steady over the cycles they compare. They also take no sample until two edges after reset, when the synchroniser holds real pin history. The bench changes configuration only at falling edges and holds every input set for at least as long as the latency under test. It samples the outputs one nanosecond after a falling edge, so every expected value corresponds to a known count of rising edges.

// File: rtl/usb_port_pwr_cond.sv
module usb_port_pwr_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_pp_en,
  input  logic cfg_pp_hi,
  input  logic cfg_oc_en,
  input  logic cfg_oc_hi,
  input  logic pwr_req,
  input  logic oc_pin,
  output logic pwr_pin,
  output logic pwr_act,
  output logic oc_flag
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          pwr_q;
  logic [1:0]    warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      pwr_q  <= 1'b0;
      warm_q <= '0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], oc_pin};
      pwr_q  <= cfg_pp_en & pwr_req & ~oc_flag;
      warm_q <= {warm_q[0], 1'b1};
    end
  end

  assign oc_flag = cfg_oc_en & (sync_q[LAST] ~^ cfg_oc_hi);
  assign pwr_act = pwr_q & cfg_pp_en;
  assign pwr_pin = cfg_pp_hi ? pwr_act : ~pwr_act;

  // R2
  oc_hi_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q[1] && cfg_oc_en && cfg_oc_hi && $past(cfg_oc_en) && $past(cfg_oc_hi))
      |-> (oc_flag == $past(oc_pin, SYNC_STAGES)));

  // R4
  oc_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_oc_en |-> !oc_flag);

  // R5
  pwr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q[0] && cfg_pp_en && $past(cfg_pp_en))
      |-> (pwr_act == ($past(pwr_req) && !$past(oc_flag))));

  // R7
  pp_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pp_en |-> (pwr_pin == !cfg_pp_hi && !pwr_act));

  // R8
  oc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flag && cfg_pp_en) |=> !pwr_act);

endmodule

// File: tb/usb_port_pwr_cond_bench.sv
`timescale 1ns/1ps
module usb_port_pwr_cond_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pp_en = 1'b0, cfg_pp_hi = 1'b0, cfg_oc_en = 1'b0, cfg_oc_hi = 1'b0;
  logic pwr_req = 1'b0, oc_pin = 1'b1;
  logic pwr_pin, pwr_act, oc_flag;

  always #2 clk = ~clk;

  usb_port_pwr_cond u_usb_port_pwr_cond (
    .clk(clk), .rst_n(rst_n),
    .cfg_pp_en(cfg_pp_en), .cfg_pp_hi(cfg_pp_hi),
    .cfg_oc_en(cfg_oc_en), .cfg_oc_hi(cfg_oc_hi),
    .pwr_req(pwr_req), .oc_pin(oc_pin),
    .pwr_pin(pwr_pin), .pwr_act(pwr_act), .oc_flag(oc_flag)
  );

  typedef struct {
    logic  e_pin;
    logic  e_act;
    logic  e_flag;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic drive(input int n, input logic ppen, input logic pphi,
                       input logic ocen, input logic ochi, input logic req,
                       input logic pin, input logic e_pin, input logic e_act,
                       input logic e_flag, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_pp_en = ppen; cfg_pp_hi = pphi; cfg_oc_en = ocen; cfg_oc_hi = ochi;
    pwr_req = req; oc_pin = pin;
    repeat (n) @(negedge clk);
    e.e_pin = e_pin; e.e_act = e_act; e.e_flag = e_flag; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      wait (q.size() > 0);
      #1;
      e = q.pop_front();
      n_vec++;
      if (pwr_pin !== e.e_pin || pwr_act !== e.e_act || oc_flag !== e.e_flag) begin
        n_bad++;
        $display("FAIL %s: pin/act/flag actual %b%b%b expected %b%b%b",
                 e.tag, pwr_pin, pwr_act, oc_flag, e.e_pin, e.e_act, e.e_flag);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin : stim
    // R1: in reset, power control off, active-low polarity, sensing off
    drive(2, 0, 0, 0, 0, 1, 1, 1'b1, 1'b0, 1'b0, "R1 reset lowpol");
    drive(1, 0, 1, 0, 1, 1, 1, 1'b0, 1'b0, 1'b0, "R1 reset hipol");
    @(negedge clk); rst_n = 1'b1;
    // R5 R6: request granted, active-high pin
    drive(3, 1, 1, 1, 1, 1, 0, 1'b1, 1'b1, 1'b0, "R5 grant");
    // R6: polarity flips the pin in the same cycle
    drive(0, 1, 0, 1, 1, 1, 0, 1'b0, 1'b1, 1'b0, "R6 lowpol same cycle");
    drive(0, 1, 1, 1, 1, 1, 0, 1'b1, 1'b1, 1'b0, "R6 hipol same cycle");
    // R5: request dropped
    drive(1, 1, 0, 1, 1, 0, 0, 1'b1, 1'b0, 1'b0, "R5 drop");
    drive(1, 1, 0, 1, 1, 1, 0, 1'b0, 1'b1, 1'b0, "R5 regrant");
    // R2 and R8: active-high overcurrent, exact latencies
    drive(1, 1, 1, 1, 1, 1, 1, 1'b1, 1'b1, 1'b0, "R2 one edge no flag");
    drive(0, 1, 1, 1, 1, 1, 1, 1'b1, 1'b1, 1'b1, "R2 two edges flag");
    drive(0, 1, 1, 1, 1, 1, 1, 1'b0, 1'b0, 1'b1, "R8 cut next cycle");
    drive(3, 1, 1, 1, 1, 1, 1, 1'b0, 1'b0, 1'b1, "R8 held off");
    drive(3, 1, 1, 1, 1, 1, 0, 1'b1, 1'b1, 1'b0, "R2 clear regrant");
    // R3: active-low overcurrent
    drive(3, 1, 1, 1, 0, 1, 0, 1'b0, 1'b0, 1'b1, "R3 low asserts");
    drive(3, 1, 1, 1, 0, 1, 1, 1'b1, 1'b1, 1'b0, "R3 high clear");
    // R4: sensing disabled masks both levels
    drive(3, 1, 1, 0, 0, 1, 0, 1'b1, 1'b1, 1'b0, "R4 masked low");
    drive(3, 1, 1, 0, 1, 1, 1, 1'b1, 1'b1, 1'b0, "R4 masked high");
    // R7: control disabled forces the inactive level at once
    drive(0, 0, 1, 0, 1, 1, 0, 1'b0, 1'b0, 1'b0, "R7 off hipol");
    drive(0, 0, 0, 0, 1, 1, 0, 1'b1, 1'b0, 1'b0, "R7 off lowpol");
    drive(3, 0, 0, 1, 1, 1, 0, 1'b1, 1'b0, 1'b0, "R7 stays off");
    drive(2, 1, 0, 1, 1, 1, 0, 1'b0, 1'b1, 1'b0, "R5 reenable");
    done = 1'b1;
    report();
  end

endmodule